// File: doc/BRIEF.md
# Key-Guarded Watchdog Counter

This block is a memory-mapped watchdog. A counter register climbs by one on every clock while the watchdog runs. Software seeds it with a negative timeout, so it reaches the all-ones value and wraps after a known number of cycles. On that wrap the block raises a one-cycle expiry pulse and latches an overflow status flag. It then reloads the counter from a load register, so an unattended watchdog keeps firing at a fixed period. Software keeps it quiet by stopping it, rewriting the counter with the timeout and starting it again.

Running and stopping cannot be switched by a single stray write. Each change needs two specific words written in order to a control register. Every accepted write to that register opens a fixed busy window, and a posted-write flag stays visible for the whole window. The run state follows a valid pair only at the moment that flag drops. Writes that arrive while the flag is set are dropped, so software polls the flag between the two words. Read data is registered, so a read returns the state from one clock before.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped. Counter (0x28), load (0x2C), status (0x18) and posted-write status (0x34) all read 0, and the expiry output is low. Bit 0 of offset 0x14 reads 1 once reset has been released.
- R2: Counter (0x28) and load (0x2C) can be written and read back. Read data appears on the bus one clock after the address is presented.
- R3: While running, the counter rises by exactly one per clock. While stopped it holds its value unless it is written.
- R4: When the running counter holds all-ones, the next clock loads it from the load register, pulses the expiry output high for one cycle and sets status bit 0 at 0x18. The expiry period in cycles is therefore the two's-complement magnitude of the load value.
- R5: Writing a word with bit 0 set to offset 0x18 clears the overflow flag. Writing a word with bit 0 clear leaves it unchanged.
- R6: Writing 0xBBBB and then 0x4444 to offset 0x48 starts the watchdog.
- R7: Writing 0xAAAA and then 0x5555 to offset 0x48 stops the watchdog.
- R8: If the second accepted word is not the partner of the first, the pair is discarded and the run state is unchanged. A lone second word does nothing.
- R9: Bit 4 of offset 0x34 is 1 for exactly PEND_CYC (default 4) clocks after each accepted write to 0x48.
- R10: The run state changes on the same clock that bit 4 of 0x34 clears, never earlier.
- R11: A write to 0x48 while bit 4 of 0x34 is set is ignored: it neither extends the busy window nor advances the key sequence. Offset 0x48 reads back the last accepted word.
- R12: A stop, a counter rewrite and a restart refresh the watchdog, so it does not expire within the original timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for bus_addr |
| wdt_expire | output | 1 | One-cycle expiry pulse on counter wrap |

## Verification
The assertions check on every cycle several timing rules. The run state moves only on the clock where the busy flag falls. A write that lands in the busy window leaves the accepted-word register untouched. A stopped counter holds unless it is written. An expiry pulse comes only from a running watchdog, sets the overflow flag and leaves the counter holding the load value. Only the bench scenarios can show the things that need whole sequences to play out. These are the accepted and rejected key pairs, the exact four-cycle width of the busy flag, the expiry period for a sweep of load values and a refresh that keeps the watchdog from expiring.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_RSTDONE = 8'h14;
  localparam logic [7:0] OFS_STATUS  = 8'h18;
  localparam logic [7:0] OFS_COUNT   = 8'h28;
  localparam logic [7:0] OFS_LOAD    = 8'h2C;
  localparam logic [7:0] OFS_POST    = 8'h34;
  localparam logic [7:0] OFS_SS      = 8'h48;

  localparam logic [15:0] KEY_STOP_A = 16'hAAAA;
  localparam logic [15:0] KEY_STOP_B = 16'h5555;
  localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
  localparam logic [15:0] KEY_RUN_B  = 16'h4444;

  localparam int POST_BIT = 4;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_STOP_A, SEQ_RUN_A} seq_t;

  typedef struct packed {
    logic ss;
    logic count;
    logic load;
    logic status;
  } wsel_t;
endpackage

// File: rtl/wdt_bus.sv
module wdt_bus
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] cnt,
  input  logic [DATA_W-1:0] load,
  input  logic              ovf,
  input  logic              pend,
  input  logic [DATA_W-1:0] ss_word,
  output wsel_t             wsel,
  output logic [DATA_W-1:0] rdata
);
  logic rst_done;

  always_comb begin
    wsel.ss     = we && (addr == ADDR_W'(OFS_SS));
    wsel.count  = we && (addr == ADDR_W'(OFS_COUNT));
    wsel.load   = we && (addr == ADDR_W'(OFS_LOAD));
    wsel.status = we && (addr == ADDR_W'(OFS_STATUS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_done <= 1'b0;
      rdata    <= '0;
    end else begin
      rst_done <= 1'b1;
      if (addr == ADDR_W'(OFS_RSTDONE))     rdata <= DATA_W'(rst_done);
      else if (addr == ADDR_W'(OFS_STATUS)) rdata <= DATA_W'(ovf);
      else if (addr == ADDR_W'(OFS_COUNT))  rdata <= cnt;
      else if (addr == ADDR_W'(OFS_LOAD))   rdata <= load;
      else if (addr == ADDR_W'(OFS_POST))   rdata <= DATA_W'(pend) << POST_BIT;
      else if (addr == ADDR_W'(OFS_SS))     rdata <= ss_word;
      else                                  rdata <= '0;
    end
  end

  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wsel.ss, wsel.count, wsel.load, wsel.status}));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PEND_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              pend,
  output logic              running,
  output logic [DATA_W-1:0] ss_word
);
  localparam int PW = $clog2(PEND_CYC + 1);

  logic [PW-1:0] pend_cnt;
  seq_t          seq;
  logic          cmd_vld;
  logic          cmd_run;
  logic          accept;

  assign pend   = (pend_cnt != '0);
  assign accept = ss_we && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cnt <= '0;
      seq      <= SEQ_IDLE;
      cmd_vld  <= 1'b0;
      cmd_run  <= 1'b0;
      running  <= 1'b0;
      ss_word  <= '0;
    end else if (accept) begin
      pend_cnt <= PW'(PEND_CYC);
      ss_word  <= wdata;
      if (wdata == DATA_W'(KEY_STOP_A)) begin
        seq <= SEQ_STOP_A;
      end else if (wdata == DATA_W'(KEY_RUN_A)) begin
        seq <= SEQ_RUN_A;
      end else if (seq == SEQ_STOP_A && wdata == DATA_W'(KEY_STOP_B)) begin
        seq     <= SEQ_IDLE;
        cmd_vld <= 1'b1;
        cmd_run <= 1'b0;
      end else if (seq == SEQ_RUN_A && wdata == DATA_W'(KEY_RUN_B)) begin
        seq     <= SEQ_IDLE;
        cmd_vld <= 1'b1;
        cmd_run <= 1'b1;
      end else begin
        seq <= SEQ_IDLE;
      end
    end else if (pend) begin
      pend_cnt <= pend_cnt - PW'(1);
      if (pend_cnt == PW'(1) && cmd_vld) begin
        running <= cmd_run;
        cmd_vld <= 1'b0;
      end
    end
  end

  p_run_at_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(running) |-> $fell(pend));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (ss_we && pend) |=> $stable(ss_word));

  p_pend_opens_r9: assert property (@(posedge clk) disable iff (rst)
    (ss_we && !pend) |=> pend);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic              cnt_we,
  input  logic              load_we,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] load,
  output logic              ovf,
  output logic              expire
);
  logic wrap;

  assign wrap = running && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      load   <= '0;
      ovf    <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= wrap;
      if (cnt_we)       cnt <= wdata;
      else if (wrap)    cnt <= load;
      else if (running) cnt <= cnt + DATA_W'(1);
      if (load_we) load <= wdata;
      if (wrap)                  ovf <= 1'b1;
      else if (sts_we && wdata[0]) ovf <= 1'b0;
    end
  end

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!running && !cnt_we) |=> $stable(cnt));

  p_step_running_r3: assert property (@(posedge clk) disable iff (rst)
    (running && !cnt_we && cnt != '1) |=> (cnt == $past(cnt) + DATA_W'(1)));

  p_expire_flag_r4: assert property (@(posedge clk) disable iff (rst)
    expire |-> ovf);

  p_expire_running_r4: assert property (@(posedge clk) disable iff (rst)
    expire |-> $past(running));

  p_expire_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (expire && !$past(cnt_we) && !$past(load_we)) |-> (cnt == load));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PEND_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdt_expire
);
  wsel_t             wsel;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] load;
  logic [DATA_W-1:0] ss_word;
  logic              ovf;
  logic              pend;
  logic              running;

  wdt_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
    .cnt(cnt), .load(load), .ovf(ovf), .pend(pend), .ss_word(ss_word),
    .wsel(wsel), .rdata(bus_rdata)
  );

  wdt_keyseq #(.DATA_W(DATA_W), .PEND_CYC(PEND_CYC)) u_seq (
    .clk(clk), .rst(rst), .ss_we(wsel.ss), .wdata(bus_wdata),
    .pend(pend), .running(running), .ss_word(ss_word)
  );

  wdt_count #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .running(running),
    .cnt_we(wsel.count), .load_we(wsel.load), .sts_we(wsel.status),
    .wdata(bus_wdata), .cnt(cnt), .load(load), .ovf(ovf), .expire(wdt_expire)
  );
endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_expire;

  int n_chk = 0;
  int n_bad = 0;
  int n_pulse = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_expire(wdt_expire)
  );

  always @(negedge clk) if (!rst && wdt_expire) n_pulse++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20; i++) begin
      rd(8'h34, v);
      if (v[4] == 1'b0) break;
    end
  endtask

  task automatic keys(input logic [31:0] a, input logic [31:0] b);
    wr(8'h48, a); wait_idle();
    wr(8'h48, b); wait_idle();
  endtask

  task automatic check_running(input string req, input bit exp_run);
    logic [31:0] v1, v2;
    rd(8'h28, v1);
    rd(8'h28, v2);
    chk(req, v2 - v1, exp_run ? 32'd1 : 32'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(8'h14, v); chk("R1 reset-done", v & 32'h1, 32'h1);
    rd(8'h28, v); chk("R1 counter", v, 32'h0);
    rd(8'h2C, v); chk("R1 load", v, 32'h0);
    rd(8'h18, v); chk("R1 status", v, 32'h0);
    rd(8'h34, v); chk("R1 posted", v, 32'h0);
    chk("R1 expire", {31'h0, wdt_expire}, 32'h0);
    check_running("R1 stopped", 1'b0);

    // R2 register write/readback
    wr(8'h2C, 32'hDEAD_BEEF); rd(8'h2C, v); chk("R2 load", v, 32'hDEAD_BEEF);
    wr(8'h28, 32'h0000_0064); rd(8'h28, v); chk("R2 counter", v, 32'h64);
    check_running("R3 hold while stopped", 1'b0);

    // R9 pending width on first run key
    wr(8'h48, 32'hBBBB);
    bus_addr = 8'h34;
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bus_rdata[4]) hi++;
      if (i < 4) chk("R9 pending high", {31'h0, bus_rdata[4]}, 32'h1);
    end
    chk("R9 pending count", hi, 4);

    // R6/R10 start lands exactly when pending clears
    wr(8'h48, 32'h4444);
    bus_addr = 8'h28;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      chk("R10 start timing", bus_rdata, (i <= 5) ? 32'd100 : 32'd100 + 32'(i - 5));
    end
    check_running("R6 running", 1'b1);

    // R8 mismatched stop pair leaves it running
    keys(32'hAAAA, 32'h4444);
    check_running("R8 bad pair keeps running", 1'b1);
    wr(8'h48, 32'h5555); wait_idle();
    check_running("R8 lone second word", 1'b1);

    // R7 stop
    keys(32'hAAAA, 32'h5555);
    check_running("R7 stopped", 1'b0);

    // R8 bad start pair
    keys(32'hBBBB, 32'h5555);
    check_running("R8 bad start pair", 1'b0);

    // R11 write during pending ignored
    wr(8'h48, 32'hBBBB);
    wr(8'h48, 32'h4444);
    rd(8'h48, v); chk("R11 readback", v, 32'hBBBB);
    wait_idle();
    check_running("R11 busy write ignored", 1'b0);
    wr(8'h48, 32'h1234); wait_idle();

    // R4/R5 period sweep
    for (int n = 2; n <= 9; n++) begin
      int first, second, idx;
      bit prev;
      wr(8'h2C, 32'(-n));
      wr(8'h28, 32'(-n));
      wr(8'h18, 32'h1);
      keys(32'hBBBB, 32'h4444);
      bus_addr = 8'h28;
      first = -1; second = -1; prev = 1'b0;
      for (idx = 0; idx < 40; idx++) begin
        @(negedge clk);
        if (prev) chk("R4 reload", bus_rdata, 32'(-n));
        if (wdt_expire && !prev) begin
          if (first < 0) first = idx; else if (second < 0) second = idx;
        end
        if (prev) chk("R4 pulse width", {31'h0, wdt_expire}, 32'h0);
        prev = wdt_expire;
      end
      chk("R4 period", second - first, n);
      keys(32'hAAAA, 32'h5555);
      rd(8'h18, v); chk("R4 status set", v, 32'h1);
      wr(8'h18, 32'h0); rd(8'h18, v); chk("R5 write 0 keeps", v, 32'h1);
      wr(8'h18, 32'h1); rd(8'h18, v); chk("R5 write 1 clears", v, 32'h0);
    end

    // R12 refresh keeps it from expiring
    wr(8'h2C, 32'(-200));
    wr(8'h28, 32'(-200));
    keys(32'hBBBB, 32'h4444);
    n_pulse = 0;
    repeat (100) @(negedge clk);
    keys(32'hAAAA, 32'h5555);
    wr(8'h28, 32'(-200));
    keys(32'hBBBB, 32'h4444);
    repeat (150) @(negedge clk);
    chk("R12 no expiry", n_pulse, 0);
    rd(8'h18, v); chk("R12 status clear", v, 32'h0);
    keys(32'hAAAA, 32'h5555);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule